// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a triangle-wave timer that drives a set of PWM outputs whose pulses are centred on the bottom of each count cycle. A shared counter climbs from zero to a programmed modulus, turns round, and descends back to zero. Because every output is decided against the same rising and falling ramp, each pulse sits symmetrically about the counter minimum. Edges on different channels therefore rarely fall on the same clock.

Each channel holds a 16-bit duty value and a polarity bit. While the counter is above the duty value, the output is in its inactive state. On the way down, the counter passing the duty value makes the output active. On the way up, passing it again makes the output inactive.

The block keeps two kinds of sticky flags. A turn flag is raised when the counter reaches the modulus. A match flag per channel is raised whenever the counter equals that channel's value. Each flag has its own clear strobe. The modulus and duty values are taken straight from the input ports.

Top module: `cpwm_timer`

## Requirements
- R1: While `rst` is high, and at the first falling edge after it, `pwm_out`, `tof_flag` and `ch_flag` are all 0.
- R2: With `en` high and a modulus M > 0, the counter visits 0,1,…,M,M-1,…,1 and repeats. The period is 2·M clocks, and `tof_flag` events are 2·M clocks apart.
- R3: With polarity bit 0 and a duty value V where 0 < V < M, the output is high (active) for exactly 2·V clocks of each period. The high interval surrounds the counter minimum.
- R4: With polarity bit 1, the output is the inverse of the R3 waveform: low for 2·V clocks of each period.
- R5: A duty value of 0 keeps the output inactive for the whole period.
- R6: A duty value at or above M keeps the output active for the whole period.
- R7: With modulus 0, the counter neither counts nor turns. No flag is raised and every output stays at its inactive level.
- R8: `tof_flag` is raised in the clock after the counter equals M while counting up. It stays high until `tof_clr` is applied.
- R9: `ch_flag[i]` is raised in the clock after the counter equals channel i's value, in either direction. It stays high until `ch_clr[i]` is applied.
- R10: When an event and its clear strobe fall in the same clock, the flag is set.
- R11: With `en` low, the counter is held at zero in the descending direction and every output sits at its inactive level. The first enabled clock counts up, so the first `tof_flag` appears M+1 clocks after `en` rises.
- R12: Every output is registered. A change of counter state shows at the ports one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| modulus | input | CNT_W | Turning point of the triangle count |
| ch_val | input | N_CH*CNT_W | Duty values; channel i occupies bits [i*CNT_W +: CNT_W] |
| pol | input | N_CH | Polarity per channel; 0 = active high, 1 = active low |
| tof_clr | input | 1 | Clear strobe for the turn flag |
| ch_clr | input | N_CH | Clear strobes for the match flags |
| pwm_out | output | N_CH | PWM outputs |
| tof_flag | output | 1 | Sticky turn flag |
| ch_flag | output | N_CH | Sticky match flags |

## Verification
Every result of this block is due exactly one rising edge after the counter state or input that causes it. This covers the output levels, the turn flag and the match flags. The bench keeps a phase-indexed model of the triangle and predicts each output for the next edge from the inputs held since the previous falling edge. It then waits for the rising edge and compares at the following falling edge. Stimulus changes only at falling edges, so every prediction uses the same input values that the design sees at the edge. The counting checks for pulse width, event spacing and restart delay are made in those same one-clock units.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/cpwm_sticky.sv
module cpwm_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  // an event in the clearing clock keeps the flag up
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= set | (flag_q & ~clr);
  end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] cnt_q,
  output dir_e             dir_q,
  output logic             turn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // top of the triangle: counting up and at (or past) the modulus
  assign turn = run && (dir_q == DIR_UP) && (cnt_q >= modulus);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= modulus) begin
        dir_q <= DIR_DOWN;
        cnt_q <= cnt_q - ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        dir_q <= DIR_UP;
        cnt_q <= ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic [CNT_W-1:0] val,
  input  logic             pol,
  input  logic             clr,
  output logic             pwm_q,
  output logic             flag_q
);
  logic active;
  logic match;

  // inclusive on the rise, exclusive on the fall: 2*val states per period
  assign active = (dir == DIR_UP) ? (cnt <= val) : (cnt < val);
  assign match  = run && (cnt == val);

  always_ff @(posedge clk) begin
    if (rst)      pwm_q <= 1'b0;
    else if (run) pwm_q <= pol ^ active;
    else          pwm_q <= pol;
  end

  cpwm_sticky u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (match),
    .clr    (clr),
    .flag_q (flag_q)
  );
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [CNT_W-1:0]      modulus,
  input  logic [N_CH*CNT_W-1:0] ch_val,
  input  logic [N_CH-1:0]       pol,
  input  logic                  tof_clr,
  input  logic [N_CH-1:0]       ch_clr,
  output logic [N_CH-1:0]       pwm_out,
  output logic                  tof_flag,
  output logic [N_CH-1:0]       ch_flag
);
  logic             run;
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic             turn;

  assign run = en && (modulus != '0);

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .modulus (modulus),
    .cnt_q   (cnt_q),
    .dir_q   (dir_q),
    .turn    (turn)
  );

  cpwm_sticky u_tof (
    .clk    (clk),
    .rst    (rst),
    .set    (turn),
    .clr    (tof_clr),
    .flag_q (tof_flag)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    cpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .cnt    (cnt_q),
      .dir    (dir_q),
      .val    (ch_val[i*CNT_W +: CNT_W]),
      .pol    (pol[i]),
      .clr    (ch_clr[i]),
      .pwm_q  (pwm_out[i]),
      .flag_q (ch_flag[i])
    );
  end
endmodule

// File: rtl/cpwm_timer_checker.sv
module cpwm_timer_checker #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] modulus,
  input logic [N_CH-1:0]  pol,
  input logic [N_CH-1:0]  pwm_out,
  input logic             tof_flag,
  input logic             tof_clr,
  input logic [N_CH-1:0]  ch_flag,
  input logic [N_CH-1:0]  ch_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_up
);
  // R8: turn flag stays up until cleared
  p_tof_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (tof_flag && !tof_clr) |=> tof_flag);

  // R8: reaching the modulus while rising raises the turn flag
  p_tof_on_turn_r8: assert property (@(posedge clk) disable iff (rst)
    (en && dir_up && cnt == modulus && modulus != '0) |=> tof_flag);

  // R9: match flag of channel 0 stays up until cleared
  p_ch0_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ch_flag[0] && !ch_clr[0]) |=> ch_flag[0]);

  // R7: modulus zero never raises the turn flag
  p_mod_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (modulus == '0 && !tof_flag) |=> !tof_flag);

  // R11: disabled counter parks at zero, descending
  p_park_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !dir_up));

  // R11: disabled outputs sit at their inactive level
  p_idle_out_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_out == $past(pol)));
endmodule

bind cpwm_timer cpwm_timer_checker #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .modulus  (modulus),
  .pol      (pol),
  .pwm_out  (pwm_out),
  .tof_flag (tof_flag),
  .tof_clr  (tof_clr),
  .ch_flag  (ch_flag),
  .ch_clr   (ch_clr),
  .cnt      (cnt_q),
  .dir_up   (dir_q == cpwm_pkg::DIR_UP)
);

// File: tb/tb_cpwm_timer.sv
`timescale 1ns/1ps
module tb_cpwm_timer;
  localparam int W = 16;
  localparam int N = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en = 1'b0;
  logic [W-1:0]   modulus = '0;
  logic [N*W-1:0] ch_val = '0;
  logic [N-1:0]   pol = '0;
  logic           tof_clr = 1'b0;
  logic [N-1:0]   ch_clr = '0;
  logic [N-1:0]   pwm_out;
  logic           tof_flag;
  logic [N-1:0]   ch_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state: phase 0 is the counter minimum
  int k = 0;
  logic [N-1:0] e_pwm = '0;
  logic         e_tof = 1'b0;
  logic [N-1:0] e_chf = '0;

  always #10 clk = ~clk;

  cpwm_timer #(.CNT_W(W), .N_CH(N)) dut (
    .clk(clk), .rst(rst), .en(en), .modulus(modulus), .ch_val(ch_val),
    .pol(pol), .tof_clr(tof_clr), .ch_clr(ch_clr),
    .pwm_out(pwm_out), .tof_flag(tof_flag), .ch_flag(ch_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // predict, take one rising edge, compare at the falling edge
  task automatic tick(input string tag);
    logic [N-1:0] np, nf;
    logic nt, run, act;
    int nk, m, c, v;
    m = int'(modulus);
    run = en && (m != 0);
    if (rst) begin
      np = '0; nf = '0; nt = 1'b0; nk = 0;
    end else begin
      c = (k <= m) ? k : 2*m - k;
      for (int i = 0; i < N; i++) begin
        v = int'(ch_val[i*W +: W]);
        if (k == 0)      act = (v > 0);
        else if (k <= m) act = (k <= v);
        else             act = (c < v);
        np[i] = run ? (pol[i] ^ act) : pol[i];
        nf[i] = (run && c == v) | (e_chf[i] & ~ch_clr[i]);
      end
      nt = (run && k == m) | (e_tof & ~tof_clr);
      nk = run ? ((k + 1 >= 2*m) ? 0 : k + 1) : 0;
    end
    @(posedge clk);
    k = nk; e_pwm = np; e_tof = nt; e_chf = nf;
    @(negedge clk);
    check({tag, " pwm"}, 32'(pwm_out), 32'(e_pwm));
    check({tag, " tof"}, 32'(tof_flag), 32'(e_tof));
    check({tag, " chf"}, 32'(ch_flag), 32'(e_chf));
  endtask

  task automatic set_ch(input int i, input int v);
    ch_val[i*W +: W] = W'(v);
  endtask

  task automatic park(input int n);
    en = 1'b0; tof_clr = 1'b1; ch_clr = '1;
    for (int i = 0; i < n; i++) tick("R11");
    tof_clr = 1'b0; ch_clr = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick("R1");
    rst = 1'b0;
    tick("R1");
    check("R1 pwm after reset", 32'(pwm_out), 0);
    check("R1 flags after reset", 32'({tof_flag, ch_flag}), 0);
  endtask

  task automatic t_period;
    int last, gaps, ok;
    park(2);
    modulus = 5; set_ch(0, 2); set_ch(1, 3); pol = '0; tof_clr = 1'b1; en = 1'b1;
    last = -1; gaps = 0; ok = 1;
    for (int i = 0; i < 40; i++) begin
      tick("R2");
      if (tof_flag) begin
        if (last >= 0) begin gaps++; if (i - last != 10) ok = 0; end
        last = i;
      end
    end
    check("R2 turn spacing 2M", 32'(ok), 1);
    check("R2 turn count", 32'(gaps), 3);
    tof_clr = 1'b0;
  endtask

  task automatic t_width;
    int hi0, hi1;
    park(2);
    modulus = 6; set_ch(0, 2); set_ch(1, 4); pol = '0; en = 1'b1;
    for (int i = 0; i < 12; i++) tick("R3");
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 12; i++) begin
      tick("R3");
      hi0 += pwm_out[0]; hi1 += pwm_out[1];
    end
    check("R3 width ch0 2V", 32'(hi0), 4);
    check("R3 width ch1 2V", 32'(hi1), 8);
  endtask

  task automatic t_polarity;
    int lo;
    park(2);
    modulus = 6; set_ch(0, 2); set_ch(1, 2); pol = 2'b10; en = 1'b1;
    for (int i = 0; i < 12; i++) tick("R4");
    lo = 0;
    for (int i = 0; i < 12; i++) begin
      tick("R4");
      lo += !pwm_out[1];
      check("R4 inverse of ch0", 32'(pwm_out[1]), 32'(!pwm_out[0]));
    end
    check("R4 low width 2V", 32'(lo), 4);
  endtask

  task automatic t_extremes;
    int hi0, hi1;
    park(2);
    modulus = 5; set_ch(0, 0); set_ch(1, 7); pol = '0; en = 1'b1;
    for (int i = 0; i < 4; i++) tick("R5");
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 10; i++) begin
      tick("R6");
      hi0 += pwm_out[0]; hi1 += pwm_out[1];
    end
    check("R5 zero duty never active", 32'(hi0), 0);
    check("R6 full duty always active", 32'(hi1), 10);
    set_ch(1, 5);
    for (int i = 0; i < 10; i++) tick("R6");
    hi1 = 0;
    for (int i = 0; i < 10; i++) begin tick("R6"); hi1 += pwm_out[1]; end
    check("R6 duty equal to modulus", 32'(hi1), 10);
  endtask

  task automatic t_mod_zero;
    park(2);
    modulus = 0; set_ch(0, 0); set_ch(1, 3); pol = 2'b01; en = 1'b1;
    for (int i = 0; i < 12; i++) tick("R7");
    check("R7 outputs inactive", 32'(pwm_out), 32'b01);
    check("R7 no flags", 32'({tof_flag, ch_flag}), 0);
  endtask

  task automatic t_flags;
    int hits;
    park(2);
    modulus = 5; set_ch(0, 2); set_ch(1, 9); pol = '0; en = 1'b1;
    for (int i = 0; i < 6; i++) tick("R8");
    check("R8 turn flag raised", 32'(tof_flag), 1);
    for (int i = 0; i < 7; i++) tick("R8");
    check("R8 turn flag held", 32'(tof_flag), 1);
    check("R9 match flag held", 32'(ch_flag[0]), 1);
    check("R9 no match above modulus", 32'(ch_flag[1]), 0);
    tof_clr = 1'b1; ch_clr = '1;
    tick("R8");
    tof_clr = 1'b0; ch_clr = '0;
    // set-wins: hold clear high, count flag-high cycles over a period
    ch_clr = 2'b01; tof_clr = 1'b1; hits = 0;
    for (int i = 0; i < 10; i++) begin tick("R10"); hits += ch_flag[0]; end
    check("R10 match beats clear twice per period", 32'(hits), 2);
    ch_clr = '0; tof_clr = 1'b0;
  endtask

  task automatic t_restart;
    int n;
    park(4);
    check("R11 parked outputs", 32'(pwm_out), 32'(pol));
    modulus = 4; set_ch(0, 1); set_ch(1, 0); en = 1'b1; n = 0;
    for (int i = 0; i < 10 && !tof_flag; i++) begin tick("R11"); n++; end
    check("R11 first turn after M+1", 32'(n), 5);
    // R12: a single enabled edge changes the output one clock later
    park(2);
    pol = '0; set_ch(0, 3); en = 1'b1;
    tick("R12");
    check("R12 registered first output", 32'(pwm_out[0]), 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_period;
    t_width;
    t_polarity;
    t_extremes;
    t_mod_zero;
    t_flags;
    t_restart;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule